// File: doc/BRIEF.md
# Masked Atomic GPIO Register Block

A 32-bit general-purpose I/O controller on a simple memory-mapped register bus with single-cycle access. It holds two state words, the output value and the direction, and lets software change any group of bits without a read-modify-write. Each word has its own write-one-to-set, write-one-to-clear and write-one-to-toggle strobe registers, a direct register that takes a whole-word write, and a protect mask. A 1 in the mask freezes that bit against every kind of update.

The output word drives `pad_out` and the direction word drives `pad_oe` (1 = output). Incoming pad levels pass through a two-flop synchronizer before software can read them. This holds for every pin, so a pin configured as an output reads back the level seen on its pad.

A bus transfer happens on a rising clock edge where `bus_sel`, `bus_en` and `bus_wr` are all high for a write. For a read, `bus_wr` is low and `rd_data` is combinational from the address.

Top module: `gpio_atomic_ctrl`

## Requirements
- R1: After synchronous reset the output word, the direction word and both masks are all zero, so `pad_out` and `pad_oe` are 0.
- R2: Writing offset 0x000 sets and writing offset 0x004 clears each output bit whose data bit is 1. Bits written 0 keep their value.
- R3: Writing offset 0x008 inverts each output bit whose data bit is 1.
- R4: Offset 0x00C holds the output protect mask. It is writable, it reads back, and it is not subject to itself. While an output bit's mask bit is 1, that bit is unchanged by set, clear, toggle and direct writes.
- R5: A write to offset 0x010 loads the unprotected bits of the output word. A read of 0x010 returns the output word, which is also driven on `pad_out`.
- R6: Offsets 0x020, 0x024 and 0x028 set, clear and toggle direction bits in the same way as R2 and R3. Offset 0x030 is the direct direction register. The direction word drives `pad_oe`.
- R7: Offset 0x02C holds the direction protect mask, which gates direction set, clear, toggle and direct writes in the same way as R4.
- R8: A read of offset 0x014 returns `pad_in` after two clock edges of synchronization. A pin that is driven as an output returns its pad level.
- R9: Reads of the six strobe offsets, and reads of the reserved offsets 0x018 and 0x01C, return zero. Writes to the reserved offsets change nothing.
- R10: An update becomes visible on `pad_out`, `pad_oe` and readback right after the clock edge that completes the write. A mask change gates accesses from the next transfer onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Block selected for a transfer |
| bus_en | input | 1 | Transfer enable phase |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, zero when not reading |
| pad_in | input | 32 | Pad levels from the pins |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Output enable to the pads, 1 = drive |

## Verification
Register updates have one edge of latency. The bench drives a write on a falling edge, lets one rising edge commit it, and samples `pad_out`, `pad_oe` or a readback at the following falling edge. Pin reads have two edges of latency. The bench changes `pad_in` on a falling edge and holds a read of the pin register. It expects the old value after the first rising edge and the new value after the second. Reads are combinational, so each read is sampled shortly after its address is driven.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

    localparam logic [7:0] OFF_DSET = 8'h00;
    localparam logic [7:0] OFF_DCLR = 8'h04;
    localparam logic [7:0] OFF_DTOG = 8'h08;
    localparam logic [7:0] OFF_DMSK = 8'h0C;
    localparam logic [7:0] OFF_DVAL = 8'h10;
    localparam logic [7:0] OFF_PIN  = 8'h14;
    localparam logic [7:0] OFF_RSET = 8'h20;
    localparam logic [7:0] OFF_RCLR = 8'h24;
    localparam logic [7:0] OFF_RTOG = 8'h28;
    localparam logic [7:0] OFF_RMSK = 8'h2C;
    localparam logic [7:0] OFF_RVAL = 8'h30;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DSET, SEL_DCLR, SEL_DTOG, SEL_DMSK, SEL_DVAL,
        SEL_PIN, SEL_RSET, SEL_RCLR, SEL_RTOG, SEL_RMSK, SEL_RVAL
    } reg_sel_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic tog;
        logic direct;
        logic mask_wr;
    } upd_cmd_t;

    function automatic upd_cmd_t make_cmd(logic we, reg_sel_e sel,
                                          reg_sel_e s_set, reg_sel_e s_clr,
                                          reg_sel_e s_tog, reg_sel_e s_val,
                                          reg_sel_e s_msk);
        upd_cmd_t c;
        c.set     = we && (sel == s_set);
        c.clr     = we && (sel == s_clr);
        c.tog     = we && (sel == s_tog);
        c.direct  = we && (sel == s_val);
        c.mask_wr = we && (sel == s_msk);
        return c;
    endfunction

endpackage

// File: rtl/gpio_atomic_dec.sv
module gpio_atomic_dec
    import gpio_atomic_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned LOW_W = (ADDR_W < 8) ? ADDR_W : 8;

    logic high_zero;
    logic [7:0] low;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign high_zero = (addr[ADDR_W-1:8] == '0);
        end else begin : g_narrow
            assign high_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        low = '0;
        low[LOW_W-1:0] = addr[LOW_W-1:0];
    end

    always_comb begin
        sel = SEL_NONE;
        if (high_zero) begin
            case (low)
                OFF_DSET: sel = SEL_DSET;
                OFF_DCLR: sel = SEL_DCLR;
                OFF_DTOG: sel = SEL_DTOG;
                OFF_DMSK: sel = SEL_DMSK;
                OFF_DVAL: sel = SEL_DVAL;
                OFF_PIN:  sel = SEL_PIN;
                OFF_RSET: sel = SEL_RSET;
                OFF_RCLR: sel = SEL_RCLR;
                OFF_RTOG: sel = SEL_RTOG;
                OFF_RMSK: sel = SEL_RMSK;
                OFF_RVAL: sel = SEL_RVAL;
                default:  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_atomic_word.sv
module gpio_atomic_word
    import gpio_atomic_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_cmd_t         cmd,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] val_q,
    output logic [WIDTH-1:0] mask_q
);
    logic [WIDTH-1:0] eff;
    logic [WIDTH-1:0] val_d;

    always_comb begin
        eff   = wdata & ~mask_q;
        val_d = val_q;
        if (cmd.set)    val_d = val_q | eff;
        if (cmd.clr)    val_d = val_q & ~eff;
        if (cmd.tog)    val_d = val_q ^ eff;
        if (cmd.direct) val_d = (val_q & mask_q) | eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= '0;
            mask_q <= '0;
        end else begin
            val_q <= val_d;
            if (cmd.mask_wr) mask_q <= wdata;
        end
    end

    // R4 / R7: protected bits never move on any value update
    a_r4_masked_bits_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.set || cmd.clr || cmd.tog || cmd.direct) |=>
        ((val_q & $past(mask_q)) == ($past(val_q) & $past(mask_q))));

    // R2: set makes every unprotected written bit high
    a_r2_set_drives_high: assert property (@(posedge clk) disable iff (rst)
        cmd.set |=> ((val_q & $past(wdata & ~mask_q)) == $past(wdata & ~mask_q)));

    // R2: clear makes every unprotected written bit low
    a_r2_clr_drives_low: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> ((val_q & $past(wdata & ~mask_q)) == '0));

    // R3: toggle inverts exactly the unprotected written bits
    a_r3_toggle_inverts: assert property (@(posedge clk) disable iff (rst)
        cmd.tog |=> ((val_q ^ $past(val_q)) == $past(wdata & ~mask_q)));
endmodule

// File: rtl/gpio_atomic_sync.sv
module gpio_atomic_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_q
);
    logic [WIDTH-1:0] stage1_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk) begin
        stage1_q <= pad_in;
        pin_q    <= stage1_q;
    end

    always_ff @(posedge clk) begin
        if (rst)               warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R8: the readable pin word lags the pad by two edges
    a_r8_two_stage_lag: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (pin_q == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_atomic_ctrl.sv
module gpio_atomic_ctrl
    import gpio_atomic_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    reg_sel_e         sel;
    logic             we;
    logic             re;
    upd_cmd_t         dat_cmd;
    upd_cmd_t         dir_cmd;
    logic [WIDTH-1:0] dat_q, dat_mask;
    logic [WIDTH-1:0] dir_q, dir_mask;
    logic [WIDTH-1:0] pin_q;

    assign we = bus_sel && bus_en && bus_wr;
    assign re = bus_sel && bus_en && !bus_wr;

    gpio_atomic_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign dat_cmd = make_cmd(we, sel, SEL_DSET, SEL_DCLR, SEL_DTOG, SEL_DVAL, SEL_DMSK);
    assign dir_cmd = make_cmd(we, sel, SEL_RSET, SEL_RCLR, SEL_RTOG, SEL_RVAL, SEL_RMSK);

    gpio_atomic_word #(.WIDTH(WIDTH)) u_dat (
        .clk    (clk),
        .rst    (rst),
        .cmd    (dat_cmd),
        .wdata  (bus_wdata),
        .val_q  (dat_q),
        .mask_q (dat_mask)
    );

    gpio_atomic_word #(.WIDTH(WIDTH)) u_dir (
        .clk    (clk),
        .rst    (rst),
        .cmd    (dir_cmd),
        .wdata  (bus_wdata),
        .val_q  (dir_q),
        .mask_q (dir_mask)
    );

    gpio_atomic_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .pin_q  (pin_q)
    );

    always_comb begin
        rd_data = '0;
        if (re) begin
            case (sel)
                SEL_DMSK: rd_data = dat_mask;
                SEL_DVAL: rd_data = dat_q;
                SEL_PIN:  rd_data = pin_q;
                SEL_RMSK: rd_data = dir_mask;
                SEL_RVAL: rd_data = dir_q;
                default:  rd_data = '0;
            endcase
        end
    end

    assign pad_out = dat_q;
    assign pad_oe  = dir_q;

    // R9: a write that hits no register leaves both pad words untouched
    a_r9_unmapped_write_inert: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R6: data-side writes never disturb the direction word
    a_r6_dir_isolated: assert property (@(posedge clk) disable iff (rst)
        (we && (sel == SEL_DSET || sel == SEL_DCLR || sel == SEL_DTOG || sel == SEL_DVAL))
        |=> $stable(pad_oe));

    // R1: immediately after reset both pad words are zero
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (pad_out == '0 && pad_oe == '0));
endmodule

// File: tb/tb_gpio_atomic_ctrl.sv
module tb_gpio_atomic_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  rd_data, pad_in = '0, pad_out, pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_atomic_ctrl dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1; bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_en = 0; bus_wr = 0;
        #1;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1; bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        bus_sel = 0; bus_en = 0;
    endtask

    task automatic t_reset();
        logic [W-1:0] r;
        check("R1 pad_out", pad_out, '0);
        check("R1 pad_oe", pad_oe, '0);
        bus_read(8'h0C, r); check("R1 data mask", r, '0);
        bus_read(8'h2C, r); check("R1 dir mask", r, '0);
    endtask

    task automatic t_set_clr();
        logic [W-1:0] r;
        bus_write(8'h00, 32'h0000_00F0);
        check("R10 set visible next edge", pad_out, 32'h0000_00F0);
        bus_write(8'h00, 32'h0000_0000);
        check("R2 zero write no effect", pad_out, 32'h0000_00F0);
        bus_write(8'h04, 32'h0000_0030);
        check("R2 clear", pad_out, 32'h0000_00C0);
        bus_read(8'h10, r); check("R5 readback", r, 32'h0000_00C0);
    endtask

    task automatic t_toggle();
        bus_write(8'h08, 32'hFF00_00FF);
        check("R3 toggle", pad_out, 32'hFF00_003F);
        bus_write(8'h08, 32'hFF00_0000);
        check("R3 toggle back", pad_out, 32'h0000_003F);
    endtask

    task automatic t_direct();
        logic [W-1:0] r;
        bus_write(8'h10, 32'hA5A5_5A5A);
        check("R5 direct write", pad_out, 32'hA5A5_5A5A);
        bus_read(8'h10, r); check("R5 direct readback", r, 32'hA5A5_5A5A);
    endtask

    task automatic t_data_mask();
        logic [W-1:0] r;
        bus_write(8'h10, 32'h0000_0000);
        bus_write(8'h0C, 32'h0000_FFFF);
        bus_read(8'h0C, r); check("R4 mask readback", r, 32'h0000_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        check("R4 set gated", pad_out, 32'hFFFF_0000);
        bus_write(8'h0C, 32'hFFFF_0000);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R4 clear gated", pad_out, 32'hFFFF_0000);
        bus_write(8'h08, 32'hFFFF_FFFF);
        check("R4 toggle gated", pad_out, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'h0000_0000);
        check("R4 direct gated", pad_out, 32'hFFFF_0000);
        bus_write(8'h0C, 32'h0000_0000);
        bus_write(8'h10, 32'h0000_0000);
        check("R4 mask removed", pad_out, '0);
    endtask

    task automatic t_dir();
        logic [W-1:0] r;
        bus_write(8'h20, 32'h0000_0F0F);
        check("R6 dir set", pad_oe, 32'h0000_0F0F);
        bus_write(8'h24, 32'h0000_0003);
        check("R6 dir clear", pad_oe, 32'h0000_0F0C);
        bus_write(8'h28, 32'h0000_00FF);
        check("R6 dir toggle", pad_oe, 32'h0000_0FF3);
        bus_write(8'h30, 32'h1234_5678);
        check("R6 dir direct", pad_oe, 32'h1234_5678);
        bus_read(8'h30, r); check("R6 dir readback", r, 32'h1234_5678);
        check("R6 data untouched", pad_out, '0);
    endtask

    task automatic t_dir_mask();
        bus_write(8'h30, 32'h0000_0000);
        bus_write(8'h2C, 32'hF000_000F);
        bus_write(8'h20, 32'hFFFF_FFFF);
        check("R7 dir set gated", pad_oe, 32'h0FFF_FFF0);
        bus_write(8'h28, 32'hFFFF_FFFF);
        check("R7 dir toggle gated", pad_oe, 32'h0000_0000);
        bus_write(8'h2C, 32'h0000_0000);
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'hFFFF_FFFF);
        check("R7 dir clear gated", pad_oe, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'h0000_0000);
        check("R7 dir direct gated", pad_oe, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'h0000_0000);
    endtask

    task automatic t_pin_sync();
        @(negedge clk);
        pad_in = 32'h0000_0000;
        @(negedge clk); @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        bus_sel = 1; bus_en = 1; bus_wr = 0; bus_addr = 8'h14;
        #1 check("R8 pin before edge", rd_data, 32'h0000_0000);
        @(negedge clk); #1 check("R8 pin after one edge", rd_data, 32'h0000_0000);
        @(negedge clk); #1 check("R8 pin after two edges", rd_data, 32'hDEAD_BEEF);
        bus_sel = 0; bus_en = 0;
    endtask

    task automatic t_zero_reads();
        logic [W-1:0] r;
        bus_write(8'h10, 32'h5555_AAAA);
        bus_write(8'h30, 32'h00FF_00FF);
        bus_read(8'h00, r); check("R9 data set reads zero", r, '0);
        bus_read(8'h08, r); check("R9 data toggle reads zero", r, '0);
        bus_read(8'h24, r); check("R9 dir clear reads zero", r, '0);
        bus_read(8'h18, r); check("R9 reserved reads zero", r, '0);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h1C, 32'h0000_0000);
        check("R9 reserved write data", pad_out, 32'h5555_AAAA);
        check("R9 reserved write dir", pad_oe, 32'h00FF_00FF);
        bus_read(8'h1C, r); check("R9 reserved 1C zero", r, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_set_clr();
        t_toggle();
        t_direct();
        t_data_mask();
        t_dir();
        t_dir_mask();
        t_pin_sync();
        t_zero_reads();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule